// File: doc/BRIEF.md
# Watchdog Timer with Programmable Reset Pulse

This block is a memory-mapped watchdog peripheral. A 32-bit up-counter advances once per counter clock while enabled. When it steps onto the value held in a match register, a set of match actions selected by a match-action register takes effect. It can raise a sticky interrupt flag, stop the counter, clear the counter, start a reset pulse on an internal and/or an external reset output, and drive an external match pin low, high or toggled. The reset pulse length comes from a 16-bit register and lasts that value plus six clocks. Two force bits drive either reset output directly. A status bit records that the watchdog has driven a reset, and only the power-on reset input clears it.

Software reaches eight word registers through a single-cycle register bus. A write is taken on the clock edge where `sel_i` and `we_i` are high, and read data is combinational from the address. The usual service sequence is to hold the counter at zero through the clear bit, program the match value, pulse length and actions, and then enable counting. Re-running that sequence before the match acts as the keep-alive. A pause bit lets a debug-halt input freeze the count.

Word index (address bits 4:2): 0 interrupt status, 1 control, 2 counter (read-only), 3 match action, 4 match value, 5 pin control, 6 pulse length, 7 reset status.

Top module: `wdg_timer`

## Requirements
- R1: After `rst_ni` is low, every register reads zero except the match value, which reads 0xFFFFFFFF. `irq_o`, `rst_int_o`, `rst_ext_o` and `match_pin_o` are low.
- R2: With control bit 0 (run) set, the counter (word 2) increases by one on every clock, wrapping after all ones. The first increment happens on the edge after the write that sets run.
- R3: While control bit 1 (hold clear) is set, the counter reads zero from the cycle after the write that sets it, whatever run is.
- R4: When control bit 2 is set and `halt_i` is high, the counter holds its value. When bit 2 is clear, `halt_i` has no effect.
- R5: A match event is a clock edge on which the counter steps onto the match value. If match-action bit 0 is set, the event sets interrupt-status bit 0, which drives `irq_o`. Writing 1 to that bit clears it, and a simultaneous event wins.
- R6: If match-action bit 2 (stop) is set, a match event clears control bit 0, so the counter holds at the match value.
- R7: If match-action bit 1 (clear) is set, the counter reads zero in the cycle after it reads the match value and then counts on from zero. With bits 1 and 2 both set, it clears and then holds at zero.
- R8: A match event with match-action bit 3 (internal) or bit 4 (external) set starts a pulse that rises on the same edge the counter reaches the match value. The pulse lasts the pulse length (16 bits, word 6) plus 6 clocks on each enabled output. A match event during an active pulse is ignored.
- R9: Match-action bit 5 drives `rst_int_o` high and bit 6 drives `rst_ext_o` high for as long as each bit is set.
- R10: Pin control bit 0 reads and sets `match_pin_o`. Bits 5:4 choose the action on a match event: 0 none, 1 drive low, 2 drive high, 3 toggle. The event action overrides a write in the same cycle.
- R11: Reset-status bit 0 (word 7) becomes 1 the cycle after either reset output is high. It stays 1, writes to it are ignored, and only `rst_ni` clears it.
- R12: Read-back returns written values masked to the implemented fields: control 3 bits, match action 7 bits, pin control bits 0 and 5:4, pulse length 16 bits, match value 32 bits. Writes to the counter and writes of 0 to interrupt status have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counter and bus clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| sel_i | input | 1 | Register access select |
| we_i | input | 1 | Write strobe, taken when sel_i is high |
| addr_i | input | 5 | Byte address, word aligned |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data, zero when sel_i is low |
| halt_i | input | 1 | Debug-halt request |
| irq_o | output | 1 | Match interrupt flag |
| rst_int_o | output | 1 | Internal reset output |
| rst_ext_o | output | 1 | External reset output |
| match_pin_o | output | 1 | External match pin |

## Verification
The assertions assume that bus accesses are word-aligned and last a single cycle. They also assume that `halt_i`, `sel_i`, `we_i`, `addr_i` and `wdata_i` settle between clock edges, so that the value sampled at an edge is the value software meant. The stimulus changes every input on the falling edge and reads outputs just after it. It keeps match values small so every event falls within a short, computable window. The bench also sweeps match value, pulse length and the choice of reset output against cycle counts computed from the requirements.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int unsigned ADDR_W = 5;

  typedef enum logic [2:0] {
    REG_IRQ   = 3'd0,
    REG_CTRL  = 3'd1,
    REG_CNT   = 3'd2,
    REG_ACT   = 3'd3,
    REG_MATCH = 3'd4,
    REG_PIN   = 3'd5,
    REG_PULSE = 3'd6,
    REG_STAT  = 3'd7
  } reg_idx_e;

  typedef struct packed {
    logic dbg_en;
    logic clr;
    logic run;
  } ctrl_t;

  typedef struct packed {
    logic frc_ext;
    logic frc_int;
    logic res_ext;
    logic res_int;
    logic stop;
    logic clr;
    logic irq_en;
  } act_t;

  typedef enum logic [1:0] {
    PIN_KEEP   = 2'd0,
    PIN_LOW    = 2'd1,
    PIN_HIGH   = 2'd2,
    PIN_TOGGLE = 2'd3
  } pin_act_e;
endpackage

// File: rtl/wdg_regs.sv
module wdg_regs
  import wdg_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned PULSE_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sel_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic               hit_i,
  input  logic               wd_rst_i,
  output ctrl_t              ctrl_o,
  output act_t               act_o,
  output logic [CNT_W-1:0]   match_o,
  output logic [PULSE_W-1:0] pulse_o,
  output logic               irq_o,
  output logic               pin_o
);
  reg_idx_e           idx;
  logic               wr;
  ctrl_t              ctrl_q;
  act_t               act_q;
  logic [CNT_W-1:0]   match_q;
  logic [PULSE_W-1:0] pulse_q;
  logic [1:0]         pin_act_q;
  logic               pin_q;
  logic               irq_q;
  logic               stat_q;

  assign idx = reg_idx_e'(addr_i[ADDR_W-1:2]);
  assign wr  = sel_i & we_i;

  wire unused_bus = ^{addr_i[1:0], wdata_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      act_q     <= '0;
      match_q   <= '1;
      pulse_q   <= '0;
      pin_act_q <= '0;
      pin_q     <= 1'b0;
      irq_q     <= 1'b0;
      stat_q    <= 1'b0;
    end else begin
      if (wr && idx == REG_CTRL)  ctrl_q    <= ctrl_t'(wdata_i[2:0]);
      if (wr && idx == REG_ACT)   act_q     <= act_t'(wdata_i[6:0]);
      if (wr && idx == REG_MATCH) match_q   <= wdata_i[CNT_W-1:0];
      if (wr && idx == REG_PULSE) pulse_q   <= wdata_i[PULSE_W-1:0];
      if (wr && idx == REG_PIN) begin
        pin_act_q <= wdata_i[5:4];
        pin_q     <= wdata_i[0];
      end
      if (wr && idx == REG_IRQ && wdata_i[0]) irq_q <= 1'b0;
      // match event side effects win over same-cycle writes
      if (hit_i) begin
        if (act_q.stop)   ctrl_q.run <= 1'b0;
        if (act_q.irq_en) irq_q      <= 1'b1;
        case (pin_act_e'(pin_act_q))
          PIN_LOW:    pin_q <= 1'b0;
          PIN_HIGH:   pin_q <= 1'b1;
          PIN_TOGGLE: pin_q <= ~pin_q;
          default:    ;
        endcase
      end
      if (wd_rst_i) stat_q <= 1'b1;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i) begin
      case (idx)
        REG_IRQ:   rdata_o[0]         = irq_q;
        REG_CTRL:  rdata_o[2:0]       = ctrl_q;
        REG_CNT:   rdata_o[CNT_W-1:0] = cnt_i;
        REG_ACT:   rdata_o[6:0]       = act_q;
        REG_MATCH: rdata_o[CNT_W-1:0] = match_q;
        REG_PIN: begin
          rdata_o[0]   = pin_q;
          rdata_o[5:4] = pin_act_q;
        end
        REG_PULSE: rdata_o[PULSE_W-1:0] = pulse_q;
        REG_STAT:  rdata_o[0]           = stat_q;
        default:   rdata_o = '0;
      endcase
    end
  end

  assign ctrl_o  = ctrl_q;
  assign act_o   = act_q;
  assign match_o = match_q;
  assign pulse_o = pulse_q;
  assign irq_o   = irq_q;
  assign pin_o   = pin_q;
endmodule

// File: rtl/wdg_count.sv
module wdg_count #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic             dbg_en_i,
  input  logic             halt_i,
  input  logic             clr_on_match_i,
  input  logic [CNT_W-1:0] match_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             hit_q;
  logic             zero_now;
  logic             step;

  // clear-on-match acts one cycle after the counter lands on the match value
  assign zero_now = clr_i | (hit_q & clr_on_match_i);
  assign step     = run_i & ~zero_now & ~(dbg_en_i & halt_i);
  assign cnt_nxt  = cnt_q + 1'b1;
  assign hit_o    = step & (cnt_nxt == match_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      hit_q <= 1'b0;
    end else begin
      hit_q <= hit_o;
      if (zero_now)  cnt_q <= '0;
      else if (step) cnt_q <= cnt_nxt;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/wdg_pulse.sv
module wdg_pulse #(
  parameter int unsigned PULSE_W     = 16,
  parameter int unsigned PULSE_EXTRA = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hit_i,
  input  logic               res_int_i,
  input  logic               res_ext_i,
  input  logic               frc_int_i,
  input  logic               frc_ext_i,
  input  logic [PULSE_W-1:0] len_i,
  output logic               rst_int_o,
  output logic               rst_ext_o
);
  localparam int unsigned REM_W = $clog2((2 ** PULSE_W) + PULSE_EXTRA);

  logic [REM_W-1:0] rem_q;
  logic             active;

  assign active = (rem_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
    end else if (hit_i && (res_int_i || res_ext_i) && !active) begin
      rem_q <= REM_W'(len_i) + REM_W'(PULSE_EXTRA);
    end else if (active) begin
      rem_q <= rem_q - 1'b1;
    end
  end

  assign rst_int_o = (active & res_int_i) | frc_int_i;
  assign rst_ext_o = (active & res_ext_i) | frc_ext_i;
endmodule

// File: rtl/wdg_timer.sv
module wdg_timer
  import wdg_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned PULSE_W     = 16,
  parameter int unsigned PULSE_EXTRA = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              halt_i,
  output logic              irq_o,
  output logic              rst_int_o,
  output logic              rst_ext_o,
  output logic              match_pin_o
);
  ctrl_t              ctrl;
  act_t               act;
  logic [CNT_W-1:0]   match;
  logic [CNT_W-1:0]   cnt;
  logic [PULSE_W-1:0] pulse_len;
  logic               hit;

  wdg_regs #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .PULSE_W(PULSE_W)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (sel_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .cnt_i   (cnt),
    .hit_i   (hit),
    .wd_rst_i(rst_int_o | rst_ext_o),
    .ctrl_o  (ctrl),
    .act_o   (act),
    .match_o (match),
    .pulse_o (pulse_len),
    .irq_o   (irq_o),
    .pin_o   (match_pin_o)
  );

  wdg_count #(
    .CNT_W(CNT_W)
  ) u_count (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .run_i         (ctrl.run),
    .clr_i         (ctrl.clr),
    .dbg_en_i      (ctrl.dbg_en),
    .halt_i        (halt_i),
    .clr_on_match_i(act.clr),
    .match_i       (match),
    .cnt_o         (cnt),
    .hit_o         (hit)
  );

  wdg_pulse #(
    .PULSE_W    (PULSE_W),
    .PULSE_EXTRA(PULSE_EXTRA)
  ) u_pulse (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hit_i    (hit),
    .res_int_i(act.res_int),
    .res_ext_i(act.res_ext),
    .frc_int_i(act.frc_int),
    .frc_ext_i(act.frc_ext),
    .len_i    (pulse_len),
    .rst_int_o(rst_int_o),
    .rst_ext_o(rst_ext_o)
  );
endmodule

// File: rtl/wdg_timer_chk.sv
module wdg_timer_chk
  import wdg_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              halt_i,
  input logic              irq_o,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  match,
  input logic              hit,
  input ctrl_t             ctrl
);
  // R2
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt != $past(cnt)) |-> (cnt == $past(cnt) + 1'b1 || cnt == '0));

  // R4
  halt_pause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ctrl.dbg_en && halt_i) |-> (cnt == $past(cnt) || cnt == '0));

  // R5
  irq_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(sel_i && we_i && addr_i[ADDR_W-1:2] == 3'd0 && wdata_i[0]));

  // R5
  irq_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(hit));

  // R8
  match_land_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(hit) |-> (cnt == $past(match)));
endmodule

bind wdg_timer wdg_timer_chk #(
  .DATA_W(DATA_W),
  .CNT_W (CNT_W)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .sel_i  (sel_i),
  .we_i   (we_i),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .halt_i (halt_i),
  .irq_o  (irq_o),
  .cnt    (cnt),
  .match  (match),
  .hit    (hit),
  .ctrl   (ctrl)
);

// File: tb/wdg_timer_test.sv
module wdg_timer_test;
  localparam logic [4:0] A_IRQ = 5'h00, A_CTRL = 5'h04, A_CNT = 5'h08, A_ACT = 5'h0C;
  localparam logic [4:0] A_MATCH = 5'h10, A_PIN = 5'h14, A_PULSE = 5'h18, A_STAT = 5'h1C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, we = 1'b0, halt = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, rst_int, rst_ext, pin;
  int          total = 0, bad = 0;

  always #2 clk = ~clk;

  wdg_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .halt_i(halt), .irq_o(irq),
    .rst_int_o(rst_int), .rst_ext_o(rst_ext), .match_pin_o(pin)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; sel = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    sel = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
  endtask

  task automatic do_reset();
    logic [31:0] v;
    @(negedge clk);
    rst_n = 1'b0; sel = 1'b0; we = 1'b0; halt = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 rst", {30'd0, rst_int, rst_ext}, 0);
    chk("R1 pin", {31'd0, pin}, 0);
    rd(A_MATCH, v); chk("R1 match", v, 32'hFFFF_FFFF);
    rd(A_STAT, v);  chk("R1/R11 status", v, 0);
    rd(A_CTRL, v);  chk("R1 ctrl", v, 0);
  endtask

  // common preamble: hold clear, program, then start counting on the next write
  task automatic arm(input logic [31:0] m, input logic [31:0] len,
                     input logic [31:0] pin_cfg, input logic [31:0] act_cfg);
    wr(A_CTRL, 32'h2);
    wr(A_MATCH, m);
    wr(A_PULSE, len);
    wr(A_PIN, pin_cfg);
    wr(A_ACT, act_cfg);
    wr(A_CTRL, 32'h1);
    sel = 1'b1; we = 1'b0; addr = A_CNT;
  endtask

  initial begin
    #(4 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v, x;

    // sweep: match value, pulse length, reset output choice (R5 R6 R8 R10 R11)
    for (int m = 1; m <= 4; m++) begin
      for (int l = 0; l <= 6; l += 3) begin
        for (int e = 1; e <= 3; e++) begin
          do_reset();
          arm(m, l, 32'h20, 32'h5 | (e[0] ? 32'h8 : 0) | (e[1] ? 32'h10 : 0));
          for (int i = 1; i <= m + l + 8; i++) begin
            logic win;
            @(negedge clk); #1;
            win = (i >= m) && (i <= m + l + 5);
            chk("R6 count", rdata, (i < m) ? i : m);
            chk("R8 int pulse", {31'd0, rst_int}, {31'd0, e[0] & win});
            chk("R8 ext pulse", {31'd0, rst_ext}, {31'd0, e[1] & win});
            chk("R5 irq", {31'd0, irq}, {31'd0, i >= m});
            chk("R10 pin high", {31'd0, pin}, {31'd0, i >= m});
          end
          rd(A_CTRL, v); chk("R6 run cleared", v, 0);
          rd(A_STAT, v); chk("R11 status set", v, 1);
          wr(A_STAT, 0);
          rd(A_STAT, v); chk("R11 write ignored", v, 1);
          wr(A_IRQ, 1);
          chk("R5 irq cleared", {31'd0, irq}, 0);
        end
      end
    end

    // R2 R3: counting and hold clear
    do_reset();
    wr(A_CTRL, 32'h3);
    repeat (4) @(negedge clk);
    rd(A_CNT, v); chk("R3 clear dominates run", v, 0);
    wr(A_CTRL, 32'h1);
    repeat (3) @(negedge clk);
    rd(A_CNT, v); chk("R2 count three", v, 3);
    wr(A_CTRL, 32'h3);
    @(negedge clk);
    rd(A_CNT, v); chk("R3 clear next cycle", v, 0);

    // R4: debug pause
    do_reset();
    wr(A_CTRL, 32'h5);
    @(negedge clk);
    rd(A_CNT, v); chk("R4 before halt", v, 1);
    halt = 1'b1;
    repeat (4) @(negedge clk);
    rd(A_CNT, v); chk("R4 halted", v, 1);
    halt = 1'b0;
    repeat (2) @(negedge clk);
    rd(A_CNT, v); chk("R4 resumed", v, 3);
    wr(A_CTRL, 32'h1);
    halt = 1'b1;
    rd(A_CNT, x);
    repeat (3) @(negedge clk);
    rd(A_CNT, v); chk("R4 halt ignored", v, x + 3);
    halt = 1'b0;

    // R7 R10: clear on match with toggling pin
    do_reset();
    arm(2, 0, 32'h30, 32'h2);
    for (int i = 1; i <= 9; i++) begin
      @(negedge clk); #1;
      chk("R7 clear seq", rdata, i % 3);
      chk("R10 toggle", {31'd0, pin}, {31'd0, ((i + 1) / 3) % 2 == 1});
    end

    // R7: clear plus stop holds at zero
    do_reset();
    arm(3, 0, 32'h0, 32'h6);
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk); #1;
      chk("R7 clear hold", rdata, (i <= 3) ? i : 0);
    end
    rd(A_CTRL, v); chk("R7 run cleared", v, 0);

    // R8: event during active pulse ignored
    do_reset();
    arm(1, 10, 32'h0, 32'h12);
    for (int i = 1; i <= 19; i++) begin
      @(negedge clk); #1;
      chk("R8 retrigger ext", {31'd0, rst_ext}, {31'd0, (i <= 16) || (i == 19)});
      chk("R8 retrigger int", {31'd0, rst_int}, 0);
    end

    // R10: drive-low action
    do_reset();
    wr(A_PIN, 32'h11);
    rd(A_PIN, v); chk("R10 pin readback", v, 32'h11);
    chk("R10 pin set", {31'd0, pin}, 1);
    arm(2, 0, 32'h11, 32'h0);
    for (int i = 1; i <= 3; i++) begin
      @(negedge clk); #1;
      chk("R10 pin low", {31'd0, pin}, {31'd0, i < 2});
    end

    // R9 R11: force bits
    do_reset();
    wr(A_ACT, 32'h20);
    chk("R9 force int", {30'd0, rst_int, rst_ext}, 2);
    wr(A_ACT, 32'h40);
    chk("R9 force ext", {30'd0, rst_int, rst_ext}, 1);
    wr(A_ACT, 32'h0);
    chk("R9 release", {30'd0, rst_int, rst_ext}, 0);
    rd(A_STAT, v); chk("R11 set by force", v, 1);

    // R12: read-back masks and ignored writes
    do_reset();
    wr(A_PULSE, 32'h0001_2345);
    rd(A_PULSE, v); chk("R12 pulse", v, 32'h2345);
    wr(A_MATCH, 32'hA5A5_5A5A);
    rd(A_MATCH, v); chk("R12 match", v, 32'hA5A5_5A5A);
    wr(A_PIN, 32'hFFFF_FFFE);
    rd(A_PIN, v); chk("R12 pin ctrl", v, 32'h30);
    wr(A_ACT, 32'hFFFF_FF9F);
    rd(A_ACT, v); chk("R12 act", v, 32'h1F);
    wr(A_CNT, 32'h55);
    rd(A_CNT, v); chk("R12 counter read-only", v, 0);
    wr(A_IRQ, 32'hFFFF_FFFE);
    rd(A_IRQ, v); chk("R12 irq write zero", v, 0);
    wr(A_CTRL, 32'hFFFF_FFFA);
    rd(A_CTRL, v); chk("R12 ctrl", v, 32'h2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule